// File: doc/BRIEF.md
# Leaf Bucket Range Matcher

This block sits at the tail of a decision-tree classification pipeline. The earlier stages walk the tree and pick a leaf. This stage holds the rules of one leaf bucket. It compares an incoming 104-bit five-tuple header against every stored rule at once. It then reports which rule matched or that none did. A rule is a pair of bounds, low and high, for each of the five header fields. A header satisfies a rule only when every field lies within its bounds.

Rules are written one slot per cycle through a write port. The write carries a slot index, a valid bit and the two bound vectors. The slot number is also the rule's priority: a lower slot beats a higher one. The block takes a new header on every clock. It gives a registered answer one cycle later.

Top module: `leaf_matcher`

## Requirements
- R1: Header and bound vectors share one layout: source address [103:72], destination address [71:40], source port [39:24], destination port [23:8], protocol [7:0]. A rule matches only when all five fields of the header lie inside that rule's ranges. A single field outside its range gives no match for that rule.
- R2: Ranges are inclusive on both ends. A field equal to its low bound or its high bound is inside the range. A field one below the low bound or one above the high bound is outside. Setting low equal to high matches exactly one value.
- R3: A slot whose valid bit is 0 never matches. Writing a slot with valid 0 empties it, whatever bounds are written with it.
- R4: When several valid rules match, res_id is the lowest matching slot index.
- R5: On a miss, res_vld is 1, res_hit is 0 and res_id is all ones.
- R6: A header presented with pkt_vld high at clock edge k gives its result on res_vld/res_hit/res_id after edge k. Headers may arrive on every consecutive cycle, and each gets its own result.
- R7: A rule write at edge k applies to headers sampled at edge k+1 and later. A header sampled at the same edge k as the write is matched against the slot's previous contents.
- R8: Synchronous active-high reset empties every slot and drives res_vld=0, res_hit=0 and res_id all ones.
- R9: After an edge where pkt_vld is low, res_vld and res_hit are 0 and res_id is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rule_we | input | 1 | Write one rule slot this cycle |
| rule_slot | input | IDW (3) | Slot written; lower index has higher priority |
| rule_on | input | 1 | Valid bit stored with the slot |
| rule_lo | input | 104 | Inclusive low bounds, header layout |
| rule_hi | input | 104 | Inclusive high bounds, header layout |
| pkt_vld | input | 1 | Header present this cycle |
| pkt_hdr | input | 104 | Five-tuple header |
| res_vld | output | 1 | Result valid, one cycle after pkt_vld |
| res_hit | output | 1 | Some valid rule matched |
| res_id | output | IDW (3) | Winning slot, or all ones on a miss or idle |

## Verification
The assertions assume that the inputs are driven to known values whenever reset is low. They also assume that rule_slot names an existing slot when rule_we is high. The priority and empty-slot checks rely on the compare outputs being gated by the stored valid bits and on nothing else. The stimulus holds pkt_vld and rule_we low during reset. It changes every input only half a cycle away from the sampling edge. It draws slot indices only from 0 to NSLOT-1. Random rule ranges are built around fixed field centres that stay far from zero and from all ones, so low never exceeds high and no bound wraps.

// File: rtl/clf_pkg.sv
package clf_pkg;

    localparam int SA_W    = 32;
    localparam int DA_W    = 32;
    localparam int SP_W    = 16;
    localparam int DP_W    = 16;
    localparam int PR_W    = 8;
    localparam int HDR_W   = SA_W + DA_W + SP_W + DP_W + PR_W;

    // Field order fixes bit positions: source address occupies the MSBs.
    typedef struct packed {
        logic [SA_W-1:0] src_addr;
        logic [DA_W-1:0] dst_addr;
        logic [SP_W-1:0] src_port;
        logic [DP_W-1:0] dst_port;
        logic [PR_W-1:0] proto;
    } tuple_t;

    typedef struct packed {
        logic   on;
        tuple_t lo;
        tuple_t hi;
    } rule_t;

    function automatic logic span32(input logic [31:0] v, input logic [31:0] lo,
                                    input logic [31:0] hi);
        return (v >= lo) && (v <= hi);
    endfunction

    function automatic logic span16(input logic [15:0] v, input logic [15:0] lo,
                                    input logic [15:0] hi);
        return (v >= lo) && (v <= hi);
    endfunction

    function automatic logic span8(input logic [7:0] v, input logic [7:0] lo,
                                   input logic [7:0] hi);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/clf_rule_bank.sv
module clf_rule_bank
    import clf_pkg::*;
#(
    parameter int NSLOT = 8,
    localparam int IDW  = $clog2(NSLOT)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [IDW-1:0]       slot,
    input  logic                 on,
    input  tuple_t               lo,
    input  tuple_t               hi,
    output rule_t [NSLOT-1:0]    rules
);

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        rule_t slot_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q.on <= 1'b0;
                slot_q.lo <= '0;
                slot_q.hi <= '0;
            end else if (we && (slot == IDW'(s))) begin
                slot_q.on <= on;
                slot_q.lo <= lo;
                slot_q.hi <= hi;
            end
        end
        assign rules[s] = slot_q;
    end

endmodule

// File: rtl/clf_slot_cmp.sv
module clf_slot_cmp
    import clf_pkg::*;
(
    input  tuple_t hdr,
    input  rule_t  rule,
    output logic   hit
);

    logic [4:0] fld_ok;

    always_comb begin
        fld_ok[4] = span32(hdr.src_addr, rule.lo.src_addr, rule.hi.src_addr);
        fld_ok[3] = span32(hdr.dst_addr, rule.lo.dst_addr, rule.hi.dst_addr);
        fld_ok[2] = span16(hdr.src_port, rule.lo.src_port, rule.hi.src_port);
        fld_ok[1] = span16(hdr.dst_port, rule.lo.dst_port, rule.hi.dst_port);
        fld_ok[0] = span8 (hdr.proto,    rule.lo.proto,    rule.hi.proto);
        hit       = rule.on && (&fld_ok);
    end

endmodule

// File: rtl/clf_prio_pick.sv
module clf_prio_pick #(
    parameter int NSLOT = 8,
    localparam int IDW  = $clog2(NSLOT)
) (
    input  logic [NSLOT-1:0] req,
    output logic             any,
    output logic [IDW-1:0]   idx
);

    always_comb begin
        any = |req;
        idx = '1;
        // Walk downward so the lowest requesting slot is written last.
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (req[s]) idx = IDW'(s);
        end
    end

endmodule

// File: rtl/leaf_matcher.sv
module leaf_matcher
    import clf_pkg::*;
#(
    parameter int NSLOT = 8,
    localparam int IDW  = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rule_we,
    input  logic [IDW-1:0]   rule_slot,
    input  logic             rule_on,
    input  logic [HDR_W-1:0] rule_lo,
    input  logic [HDR_W-1:0] rule_hi,
    input  logic             pkt_vld,
    input  logic [HDR_W-1:0] pkt_hdr,
    output logic             res_vld,
    output logic             res_hit,
    output logic [IDW-1:0]   res_id
);

    rule_t [NSLOT-1:0] rules;
    logic  [NSLOT-1:0] slot_hit;
    logic  [NSLOT-1:0] slot_on;
    logic              any_hit;
    logic  [IDW-1:0]   win_idx;
    tuple_t            hdr;

    assign hdr = tuple_t'(pkt_hdr);

    clf_rule_bank #(.NSLOT(NSLOT)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (rule_we),
        .slot  (rule_slot),
        .on    (rule_on),
        .lo    (tuple_t'(rule_lo)),
        .hi    (tuple_t'(rule_hi)),
        .rules (rules)
    );

    for (genvar s = 0; s < NSLOT; s++) begin : g_cmp
        clf_slot_cmp u_cmp (
            .hdr  (hdr),
            .rule (rules[s]),
            .hit  (slot_hit[s])
        );
        assign slot_on[s] = rules[s].on;
    end

    clf_prio_pick #(.NSLOT(NSLOT)) u_pick (
        .req (slot_hit),
        .any (any_hit),
        .idx (win_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_vld <= 1'b0;
            res_hit <= 1'b0;
            res_id  <= '1;
        end else begin
            res_vld <= pkt_vld;
            res_hit <= pkt_vld && any_hit;
            res_id  <= (pkt_vld && any_hit) ? win_idx : '1;
        end
    end

    AST_EMPTY_NEVER_MATCHES: assert property (@(posedge clk) disable iff (rst)
        (slot_hit & ~slot_on) == '0);  // R3

    AST_LOWEST_SLOT_WINS: assert property (@(posedge clk) disable iff (rst)
        any_hit |-> (slot_hit[win_idx] &&
                     ((slot_hit & ((NSLOT'(1) << win_idx) - NSLOT'(1))) == '0)));  // R4

    AST_MISS_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
        (res_vld && !res_hit) |-> (&res_id));  // R5

    AST_ONE_CYCLE_RESULT: assert property (@(posedge clk) disable iff (rst)
        pkt_vld |=> res_vld);  // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !pkt_vld |=> (!res_vld && !res_hit && (&res_id)));  // R9

endmodule

// File: tb/tb_leaf_matcher.sv
module tb_leaf_matcher;

    localparam int NSLOT = 8;
    localparam int IDW   = $clog2(NSLOT);
    localparam int HW    = 104;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            rule_we = 1'b0;
    logic [IDW-1:0]  rule_slot = '0;
    logic            rule_on = 1'b0;
    logic [HW-1:0]   rule_lo = '0;
    logic [HW-1:0]   rule_hi = '0;
    logic            pkt_vld = 1'b0;
    logic [HW-1:0]   pkt_hdr = '0;
    logic            res_vld;
    logic            res_hit;
    logic [IDW-1:0]  res_id;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [HW-1:0] m_lo [NSLOT];
    logic [HW-1:0] m_hi [NSLOT];
    bit            m_on [NSLOT];
    int            exp_q[$];

    always #5 clk = ~clk;

    leaf_matcher #(.NSLOT(NSLOT)) dut (
        .clk(clk), .rst(rst), .rule_we(rule_we), .rule_slot(rule_slot),
        .rule_on(rule_on), .rule_lo(rule_lo), .rule_hi(rule_hi),
        .pkt_vld(pkt_vld), .pkt_hdr(pkt_hdr),
        .res_vld(res_vld), .res_hit(res_hit), .res_id(res_id)
    );

    function automatic logic [HW-1:0] tup(input logic [31:0] sa, input logic [31:0] da,
                                          input logic [15:0] sp, input logic [15:0] dp,
                                          input logic [7:0] pr);
        return {sa, da, sp, dp, pr};
    endfunction

    function automatic bit inside_rng(input logic [HW-1:0] h, input int s);
        bit ok;
        ok = (h[103:72] >= m_lo[s][103:72]) && (h[103:72] <= m_hi[s][103:72]);
        ok = ok && (h[71:40] >= m_lo[s][71:40]) && (h[71:40] <= m_hi[s][71:40]);
        ok = ok && (h[39:24] >= m_lo[s][39:24]) && (h[39:24] <= m_hi[s][39:24]);
        ok = ok && (h[23:8]  >= m_lo[s][23:8])  && (h[23:8]  <= m_hi[s][23:8]);
        ok = ok && (h[7:0]   >= m_lo[s][7:0])   && (h[7:0]   <= m_hi[s][7:0]);
        return ok;
    endfunction

    // Expected code: -2 idle, -1 miss, otherwise winning slot.
    function automatic int ref_result(input bit pv, input logic [HW-1:0] h);
        if (!pv) return -2;
        for (int s = 0; s < NSLOT; s++)
            if (m_on[s] && inside_rng(h, s)) return s;
        return -1;
    endfunction

    task automatic compare(input int e, input string tag);
        bit ev, eh;
        logic [IDW-1:0] ei;
        ev = (e != -2);
        eh = (e >= 0);
        ei = eh ? IDW'(e) : '1;
        n_chk++;
        if (res_vld !== ev || res_hit !== eh || res_id !== ei) begin
            n_fail++;
            $display("FAIL %s: got vld=%0b hit=%0b id=%0d, expected vld=%0b hit=%0b id=%0d",
                     tag, res_vld, res_hit, res_id, ev, eh, ei);
        end
    endtask

    // Called just after a falling edge; drives, passes one rising edge, checks.
    task automatic step(input bit pv, input logic [HW-1:0] ph, input bit we,
                        input int ws, input bit wv, input logic [HW-1:0] wl,
                        input logic [HW-1:0] wh, input string tag);
        pkt_vld   = pv;
        pkt_hdr   = ph;
        rule_we   = we;
        rule_slot = IDW'(ws);
        rule_on   = wv;
        rule_lo   = wl;
        rule_hi   = wh;
        @(posedge clk);
        exp_q.push_back(ref_result(pv, ph));
        if (we) begin
            m_on[ws] = wv;
            m_lo[ws] = wl;
            m_hi[ws] = wh;
        end
        @(negedge clk);
        compare(exp_q.pop_front(), tag);
    endtask

    task automatic wr(input int s, input bit v, input logic [HW-1:0] lo,
                      input logic [HW-1:0] hi, input string tag);
        step(1'b0, '0, 1'b1, s, v, lo, hi, tag);
    endtask

    task automatic pk(input logic [HW-1:0] h, input string tag);
        step(1'b1, h, 1'b0, 0, 1'b0, '0, '0, tag);
    endtask

    logic [HW-1:0] base_lo, base_hi, wild_lo, wild_hi;
    logic [HW-1:0] ctr [4];

    initial begin
        for (int s = 0; s < NSLOT; s++) begin
            m_on[s] = 0; m_lo[s] = '0; m_hi[s] = '0;
        end
        base_lo = tup(32'h0A00_0010, 32'hC0A8_0100, 16'd1000, 16'd80,  8'd6);
        base_hi = tup(32'h0A00_0020, 32'hC0A8_01FF, 16'd2000, 16'd80,  8'd6);
        wild_lo = '0;
        wild_hi = '1;

        repeat (3) @(negedge clk);
        // R8: outputs during and right after reset
        compare(-2, "R8 reset outputs");
        rst = 1'b0;
        pk(tup(32'h0A00_0018, 32'hC0A8_0120, 16'd1500, 16'd80, 8'd6), "R8 empty after reset");

        wr(2, 1'b1, base_lo, base_hi, "R9 idle during write");
        pk(tup(32'h0A00_0018, 32'hC0A8_0120, 16'd1500, 16'd80, 8'd6), "R1 all fields inside");
        pk(tup(32'h0A00_0010, 32'hC0A8_0100, 16'd1000, 16'd80, 8'd6), "R2 all at low bound");
        pk(tup(32'h0A00_0020, 32'hC0A8_01FF, 16'd2000, 16'd80, 8'd6), "R2 all at high bound");
        pk(tup(32'h0A00_000F, 32'hC0A8_0120, 16'd1500, 16'd80, 8'd6), "R2 src addr below low");
        pk(tup(32'h0A00_0021, 32'hC0A8_0120, 16'd1500, 16'd80, 8'd6), "R2 src addr above high");
        pk(tup(32'h0A00_0018, 32'hC0A8_0200, 16'd1500, 16'd80, 8'd6), "R1 dst addr outside");
        pk(tup(32'h0A00_0018, 32'hC0A8_0120, 16'd2001, 16'd80, 8'd6), "R1 src port outside");
        pk(tup(32'h0A00_0018, 32'hC0A8_0120, 16'd1500, 16'd81, 8'd6), "R2 exact dst port off by one");
        pk(tup(32'h0A00_0018, 32'hC0A8_0120, 16'd1500, 16'd79, 8'd6), "R2 exact dst port below");
        pk(tup(32'h0A00_0018, 32'hC0A8_0120, 16'd1500, 16'd80, 8'd17), "R1 protocol outside");
        pk(tup(32'h0B00_0000, 32'h0, 16'd0, 16'd0, 8'd0), "R5 miss gives all ones");

        // R4: wildcard in slot 5 and slot 2 overlap
        wr(5, 1'b1, wild_lo, wild_hi, "R9 idle during write");
        pk(tup(32'h0A00_0018, 32'hC0A8_0120, 16'd1500, 16'd80, 8'd6), "R4 slot 2 beats slot 5");
        pk(tup(32'h0B00_0000, 32'h0, 16'd0, 16'd0, 8'd0), "R4 only slot 5 matches");
        wr(7, 1'b1, base_lo, base_hi, "R9 idle during write");
        pk(tup(32'h0A00_0018, 32'hC0A8_0120, 16'd1500, 16'd80, 8'd6), "R4 three matches lowest wins");

        // R3: empty slot 2 with bounds that would match
        wr(2, 1'b0, base_lo, base_hi, "R9 idle during write");
        pk(tup(32'h0A00_0018, 32'hC0A8_0120, 16'd1500, 16'd80, 8'd6), "R3 emptied slot ignored");
        wr(5, 1'b0, wild_lo, wild_hi, "R9 idle during write");
        wr(7, 1'b0, base_lo, base_hi, "R9 idle during write");
        pk(tup(32'h0A00_0018, 32'hC0A8_0120, 16'd1500, 16'd80, 8'd6), "R3 all empty misses");

        // R7: write and packet at the same edge, then the next cycle
        step(1'b1, tup(32'h0A00_0018, 32'hC0A8_0120, 16'd1500, 16'd80, 8'd6),
             1'b1, 0, 1'b1, base_lo, base_hi, "R7 same-cycle write not seen");
        pk(tup(32'h0A00_0018, 32'hC0A8_0120, 16'd1500, 16'd80, 8'd6), "R7 write seen next cycle");
        step(1'b1, tup(32'h0A00_0018, 32'hC0A8_0120, 16'd1500, 16'd80, 8'd6),
             1'b1, 0, 1'b0, base_lo, base_hi, "R7 same-cycle clear not seen");
        pk(tup(32'h0A00_0018, 32'hC0A8_0120, 16'd1500, 16'd80, 8'd6), "R7 clear seen next cycle");

        // R6: back-to-back packets alternating hit and miss
        wr(4, 1'b1, base_lo, base_hi, "R9 idle during write");
        for (int i = 0; i < 6; i++)
            pk((i % 2 == 0) ? tup(32'h0A00_0011, 32'hC0A8_0101, 16'd1001, 16'd80, 8'd6)
                            : tup(32'h0A00_0001, 32'hC0A8_0101, 16'd1001, 16'd80, 8'd6),
               "R6 back-to-back");
        step(1'b0, tup(32'h0A00_0011, 32'hC0A8_0101, 16'd1001, 16'd80, 8'd6),
             1'b0, 0, 1'b0, '0, '0, "R9 matching header with pkt_vld low");

        // Random mix over all requirements
        ctr[0] = tup(32'h1000_0000, 32'h2000_0000, 16'h1000, 16'h2000, 8'h40);
        ctr[1] = tup(32'h3000_0000, 32'h4000_0000, 16'h3000, 16'h4000, 8'h50);
        ctr[2] = tup(32'h5000_0000, 32'h6000_0000, 16'h5000, 16'h6000, 8'h60);
        ctr[3] = tup(32'h7000_0000, 32'h8000_0000, 16'h7000, 16'h8000, 8'h70);
        for (int i = 0; i < 400; i++) begin
            logic [HW-1:0] c, lo, hi, h;
            logic [HW-1:0] d, j;
            int k;
            k = int'($urandom_range(0, 3));
            c = ctr[k];
            d = tup(32'($urandom_range(0, 3)), 32'($urandom_range(0, 3)),
                    16'($urandom_range(0, 3)), 16'($urandom_range(0, 3)),
                    8'($urandom_range(0, 3)));
            lo = tup(c[103:72] - d[103:72], c[71:40] - d[71:40], c[39:24] - d[39:24],
                     c[23:8] - d[23:8], c[7:0] - d[7:0]);
            hi = tup(c[103:72] + d[103:72], c[71:40] + d[71:40], c[39:24] + d[39:24],
                     c[23:8] + d[23:8], c[7:0] + d[7:0]);
            k = int'($urandom_range(0, 3));
            c = ctr[k];
            j = tup(32'($urandom_range(0, 4)), 32'($urandom_range(0, 4)),
                    16'($urandom_range(0, 4)), 16'($urandom_range(0, 4)),
                    8'($urandom_range(0, 4)));
            h = tup(c[103:72] + j[103:72] - 32'd2, c[71:40] + j[71:40] - 32'd2,
                    c[39:24] + j[39:24] - 16'd2, c[23:8] + j[23:8] - 16'd2,
                    c[7:0] + j[7:0] - 8'd2);
            step(($urandom_range(0, 3) != 0), h, ($urandom_range(0, 2) == 0),
                 int'($urandom_range(0, NSLOT - 1)), ($urandom_range(0, 4) != 0),
                 lo, hi, "R1 R4 R7 random mix");
        end

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got run still active, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule